// File: doc/BRIEF.md
# Replacement-Address Miss Predictor

This block sits beside one cache level and says, for a block address, whether an access to that level can be skipped. It keeps a small set-associative store of block addresses that the cache has recently evicted. A hit in that store means the block is known to be absent from the cache, so the answer is "definite miss". Any other outcome is "maybe", and the access must go ahead.

The cache reports each victim on the eviction port and each incoming block on the fill port. A fill removes any matching entry, so the predictor never claims a miss for a block that is resident. The query port takes one block address per cycle and answers one cycle later. A flush input empties the store. The default configuration holds 2048 addresses in 4 ways. Within a set, a new eviction replaces the ways in round-robin order.

Top module: `rmp_predictor`

## Requirements
- R1: A query presented with `query_valid_i` high gives `resp_valid_o` high on the next cycle, and `resp_valid_o` is low in every cycle that does not follow a query. `resp_miss_o` is 1 for definite miss and 0 for maybe, and it is 0 whenever `resp_valid_o` is 0.
- R2: After an eviction of address A is recorded, a query for A in a later cycle returns definite miss, as long as no fill of A, flush or replacement has removed the entry in between.
- R3: A query for an address that has never been recorded returns maybe. This includes an address in the same set as a recorded one but with a different tag.
- R4: A fill of address A invalidates any stored entry for A. A query for A in any later cycle returns maybe until A is evicted again.
- R5: When a fill and a query carry the same address in the same cycle, the query returns maybe.
- R6: A flush clears every entry and resets every set's replacement pointer to way 0. A query in the flush cycle returns maybe. Every query returns maybe until a new eviction is recorded.
- R7: Within a set, new addresses take ways 0, 1, 2, ... in turn and then wrap to way 0. With 4 ways, the fifth distinct address evicted into a set replaces the first one, and the other three stay recorded.
- R8: An eviction of an address that is already stored writes nothing and does not advance the set's replacement pointer.
- R9: When an eviction and a fill carry the same address in the same cycle, the address is not recorded.
- R10: After reset no response is pending, and every query returns maybe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Clear all entries and pointers |
| evict_valid_i | input | 1 | Eviction address is valid |
| evict_addr_i | input | ADDR_W | Block address of the victim |
| fill_valid_i | input | 1 | Fill address is valid |
| fill_addr_i | input | ADDR_W | Block address being filled |
| query_valid_i | input | 1 | Query address is valid |
| query_addr_i | input | ADDR_W | Block address to classify |
| resp_valid_o | output | 1 | Response for the previous cycle's query |
| resp_miss_o | output | 1 | 1 = definite miss, 0 = maybe |

## Verification
The properties assume that the cache reports evictions and fills honestly: an evicted address is not resident, and a resident block has had its fill reported. The check that an eviction is visible on the next cycle's query also assumes that no fill of that address arrives in the eviction cycle. The bench issues each eviction on a cycle of its own. It only pairs an eviction with a fill of the same address in the one case that tests R9, and that case is expected to answer maybe. Addresses are chosen so that each set's history is known exactly, which lets replacement order be predicted without modelling the store.

// File: rtl/rmp_pkg.sv
package rmp_pkg;
   typedef enum logic {
      RESP_MAYBE = 1'b0,
      RESP_MISS  = 1'b1
   } rmp_resp_e;
endpackage

// File: rtl/rmp_way.sv
module rmp_way #(
   parameter int SETS  = 512,
   parameter int SET_W = 9,
   parameter int TAG_W = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_i,
   input  logic [SET_W-1:0] q_set_i,
   input  logic [TAG_W-1:0] q_tag_i,
   output logic             q_hit_o,
   input  logic [SET_W-1:0] f_set_i,
   input  logic [TAG_W-1:0] f_tag_i,
   input  logic             f_en_i,
   output logic             f_hit_o,
   input  logic [SET_W-1:0] e_set_i,
   input  logic [TAG_W-1:0] e_tag_i,
   output logic             e_hit_o,
   input  logic             ins_i
);
   logic [SETS-1:0]  vld_q;
   logic [TAG_W-1:0] tag_q [SETS];

   assign q_hit_o = vld_q[q_set_i] && (tag_q[q_set_i] == q_tag_i);
   assign f_hit_o = vld_q[f_set_i] && (tag_q[f_set_i] == f_tag_i);
   assign e_hit_o = vld_q[e_set_i] && (tag_q[e_set_i] == e_tag_i);

   // insertion is applied last, so it wins over an invalidate of the same slot
   always_ff @(posedge clk) begin
      if (!rst_n || flush_i) begin
         vld_q <= '0;
      end else begin
         if (f_en_i && f_hit_o) vld_q[f_set_i] <= 1'b0;
         if (ins_i)             vld_q[e_set_i] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (ins_i && !flush_i) tag_q[e_set_i] <= e_tag_i;
   end
endmodule

// File: rtl/rmp_rr_ptr.sv
module rmp_rr_ptr #(
   parameter int SETS  = 512,
   parameter int SET_W = 9,
   parameter int WAY_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_i,
   input  logic             adv_i,
   input  logic [SET_W-1:0] set_i,
   output logic [WAY_W-1:0] ptr_o
);
   logic [WAY_W-1:0] ptr_q [SETS];

   assign ptr_o = ptr_q[set_i];

   always_ff @(posedge clk) begin
      if (!rst_n || flush_i) begin
         for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
      end else if (adv_i) begin
         ptr_q[set_i] <= ptr_q[set_i] + 1'b1;
      end
   end
endmodule

// File: rtl/rmp_predictor.sv
module rmp_predictor
   import rmp_pkg::*;
#(
   parameter int ADDR_W  = 26,
   parameter int ENTRIES = 2048,
   parameter int WAYS    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic              evict_valid_i,
   input  logic [ADDR_W-1:0] evict_addr_i,
   input  logic              fill_valid_i,
   input  logic [ADDR_W-1:0] fill_addr_i,
   input  logic              query_valid_i,
   input  logic [ADDR_W-1:0] query_addr_i,
   output logic              resp_valid_o,
   output logic              resp_miss_o
);
   localparam int SETS  = ENTRIES / WAYS;
   localparam int SET_W = $clog2(SETS);
   localparam int WAY_W = $clog2(WAYS);
   localparam int TAG_W = ADDR_W - SET_W;

   if (WAYS < 2 || (1 << WAY_W) != WAYS) begin : g_bad_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (SETS < 2 || (1 << SET_W) != SETS || SETS * WAYS != ENTRIES) begin : g_bad_sets
      $error("ENTRIES/WAYS must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W too small for the set count");
   end

   logic [WAYS-1:0]  q_hit, f_hit, e_hit, ins_en;
   logic [WAY_W-1:0] rr_ptr;
   logic             fill_eq_evict, fill_eq_query, ins_go;
   rmp_resp_e        resp_c, resp_q;
   logic             rv_q;

   assign fill_eq_evict = fill_valid_i && (fill_addr_i == evict_addr_i);
   assign fill_eq_query = fill_valid_i && (fill_addr_i == query_addr_i);
   assign ins_go = evict_valid_i && !(|e_hit) && !fill_eq_evict && !flush_i;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign ins_en[w] = ins_go && (rr_ptr == WAY_W'(w));
      rmp_way #(.SETS(SETS), .SET_W(SET_W), .TAG_W(TAG_W)) u_way (
         .clk     (clk),
         .rst_n   (rst_n),
         .flush_i (flush_i),
         .q_set_i (query_addr_i[SET_W-1:0]),
         .q_tag_i (query_addr_i[ADDR_W-1:SET_W]),
         .q_hit_o (q_hit[w]),
         .f_set_i (fill_addr_i[SET_W-1:0]),
         .f_tag_i (fill_addr_i[ADDR_W-1:SET_W]),
         .f_en_i  (fill_valid_i),
         .f_hit_o (f_hit[w]),
         .e_set_i (evict_addr_i[SET_W-1:0]),
         .e_tag_i (evict_addr_i[ADDR_W-1:SET_W]),
         .e_hit_o (e_hit[w]),
         .ins_i   (ins_en[w])
      );
   end

   rmp_rr_ptr #(.SETS(SETS), .SET_W(SET_W), .WAY_W(WAY_W)) u_rr (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush_i (flush_i),
      .adv_i   (ins_go),
      .set_i   (evict_addr_i[SET_W-1:0]),
      .ptr_o   (rr_ptr)
   );

   always_comb begin
      resp_c = RESP_MAYBE;
      if (query_valid_i && (|q_hit) && !fill_eq_query && !flush_i) resp_c = RESP_MISS;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rv_q   <= 1'b0;
         resp_q <= RESP_MAYBE;
      end else begin
         rv_q   <= query_valid_i;
         resp_q <= resp_c;
      end
   end

   assign resp_valid_o = rv_q;
   assign resp_miss_o  = (resp_q == RESP_MISS);
endmodule

// File: rtl/rmp_predictor_chk.sv
module rmp_predictor_chk #(
   parameter int ADDR_W = 26
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flush_i,
   input logic              evict_valid_i,
   input logic [ADDR_W-1:0] evict_addr_i,
   input logic              fill_valid_i,
   input logic [ADDR_W-1:0] fill_addr_i,
   input logic              query_valid_i,
   input logic [ADDR_W-1:0] query_addr_i,
   input logic              resp_valid_o,
   input logic              resp_miss_o
);
   logic empty_q;
   always_ff @(posedge clk) begin
      if (!rst_n || flush_i) empty_q <= 1'b1;
      else if (evict_valid_i) empty_q <= 1'b0;
   end

   p_resp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
      query_valid_i |=> resp_valid_o);
   p_no_spurious_resp_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !query_valid_i |=> !resp_valid_o);
   p_miss_needs_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
      resp_miss_o |-> resp_valid_o);
   p_evict_then_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (query_valid_i && $past(evict_valid_i) && !$past(flush_i) && !$past(fill_valid_i)
       && ($past(evict_addr_i) == query_addr_i) && !flush_i
       && !(fill_valid_i && fill_addr_i == query_addr_i)) |=> resp_miss_o);
   p_fill_then_maybe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (query_valid_i && $past(fill_valid_i) && ($past(fill_addr_i) == query_addr_i))
      |=> !resp_miss_o);
   p_fill_collide_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (query_valid_i && fill_valid_i && fill_addr_i == query_addr_i) |=> !resp_miss_o);
   p_flush_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (query_valid_i && (empty_q || flush_i)) |=> !resp_miss_o);
endmodule

bind rmp_predictor rmp_predictor_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .flush_i       (flush_i),
   .evict_valid_i (evict_valid_i),
   .evict_addr_i  (evict_addr_i),
   .fill_valid_i  (fill_valid_i),
   .fill_addr_i   (fill_addr_i),
   .query_valid_i (query_valid_i),
   .query_addr_i  (query_addr_i),
   .resp_valid_o  (resp_valid_o),
   .resp_miss_o   (resp_miss_o)
);

// File: tb/rmp_predictor_tb_top.sv
module rmp_predictor_tb_top;
   localparam int AW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          flush_i = 1'b0;
   logic          evict_valid_i = 1'b0;
   logic [AW-1:0] evict_addr_i = '0;
   logic          fill_valid_i = 1'b0;
   logic [AW-1:0] fill_addr_i = '0;
   logic          query_valid_i = 1'b0;
   logic [AW-1:0] query_addr_i = '0;
   logic          resp_valid_o, resp_miss_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic          miss;
      logic [AW-1:0] addr;
      string         tag;
   } exp_t;
   exp_t sb[$];

   always #2.5 clk = ~clk;

   // 16 entries, 4 ways: 4 sets, set index = address bits [1:0]
   rmp_predictor #(.ADDR_W(AW), .ENTRIES(16), .WAYS(4)) dut_i (
      .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
      .evict_valid_i(evict_valid_i), .evict_addr_i(evict_addr_i),
      .fill_valid_i(fill_valid_i), .fill_addr_i(fill_addr_i),
      .query_valid_i(query_valid_i), .query_addr_i(query_addr_i),
      .resp_valid_o(resp_valid_o), .resp_miss_o(resp_miss_o)
   );

   task automatic op(input logic ev, input logic [AW-1:0] ea,
                     input logic fi, input logic [AW-1:0] fa,
                     input logic qv, input logic [AW-1:0] qa,
                     input logic fl, input logic exp_miss, input string tag);
      @(negedge clk);
      evict_valid_i = ev;  evict_addr_i = ea;
      fill_valid_i  = fi;  fill_addr_i  = fa;
      query_valid_i = qv;  query_addr_i = qa;
      flush_i       = fl;
      if (qv) sb.push_back('{exp_miss, qa, tag});
   endtask

   task automatic evict(input logic [AW-1:0] a);
      op(1'b1, a, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, "");
   endtask
   task automatic fill(input logic [AW-1:0] a);
      op(1'b0, '0, 1'b1, a, 1'b0, '0, 1'b0, 1'b0, "");
   endtask
   task automatic query(input logic [AW-1:0] a, input logic e, input string tag);
      op(1'b0, '0, 1'b0, '0, 1'b1, a, 1'b0, e, tag);
   endtask
   task automatic flush();
      op(1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b1, 1'b0, "");
   endtask
   task automatic idle();
      op(1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, "");
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && resp_valid_o) begin
         if (sb.size() == 0) begin
            checks++; errors++;
            $display("FAIL R1: response with no query pending (actual valid=1, expected valid=0)");
         end else begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (resp_miss_o !== e.miss) begin
               errors++;
               $display("FAIL %s: addr 0x%03h miss actual=%0b expected=%0b",
                        e.tag, e.addr, resp_miss_o, e.miss);
            end
         end
      end else if (rst_n && resp_miss_o) begin
         checks++; errors++;
         $display("FAIL R1: miss without valid (actual miss=1, expected 0)");
      end
   end

   initial begin
      for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish (actual hung, expected done)");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      checks++;
      if (resp_valid_o !== 1'b0 || resp_miss_o !== 1'b0) begin
         errors++;
         $display("FAIL R10: after reset valid=%0b miss=%0b expected 0 0", resp_valid_o, resp_miss_o);
      end
      query(12'h010, 1'b0, "R10");
      // R2 / R3
      evict(12'h104);
      query(12'h104, 1'b1, "R2");
      query(12'h108, 1'b0, "R3");
      query(12'h204, 1'b0, "R3");
      // R4
      fill(12'h104);
      query(12'h104, 1'b0, "R4");
      // R5 then R4 after the colliding fill
      evict(12'h220);
      op(1'b0, '0, 1'b1, 12'h220, 1'b1, 12'h220, 1'b0, 1'b0, "R5");
      query(12'h220, 1'b0, "R4");
      // R9
      op(1'b1, 12'h440, 1'b1, 12'h440, 1'b0, '0, 1'b0, 1'b0, "");
      query(12'h440, 1'b0, "R9");
      // R6
      evict(12'h501);
      query(12'h501, 1'b1, "R2");
      op(1'b0, '0, 1'b0, '0, 1'b1, 12'h501, 1'b1, 1'b0, "R6");
      query(12'h501, 1'b0, "R6");
      query(12'h208, 1'b0, "R6");
      evict(12'h501);
      query(12'h501, 1'b1, "R6");
      // R7 round robin in set 2
      flush();
      evict(12'h012); evict(12'h022); evict(12'h032); evict(12'h042);
      query(12'h012, 1'b1, "R7");
      query(12'h042, 1'b1, "R7");
      evict(12'h052);
      query(12'h012, 1'b0, "R7");
      query(12'h022, 1'b1, "R7");
      query(12'h052, 1'b1, "R7");
      // R8 duplicate eviction in set 3
      flush();
      evict(12'h013); evict(12'h023); evict(12'h033); evict(12'h043);
      evict(12'h013);
      evict(12'h053);
      query(12'h013, 1'b0, "R8");
      query(12'h023, 1'b1, "R8");
      query(12'h053, 1'b1, "R8");
      repeat (4) idle();
      checks++;
      if (sb.size() != 0) begin
         errors++;
         $display("FAIL R1: %0d responses missing (expected 0)", sb.size());
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule